// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block forms memory addresses for a processor that has a 16-bit segmented address space. For each request it takes five inputs: an access-type code, the base and index selects, a displacement with a width mode, the four segment register values and the pointer registers. From these it builds a 16-bit offset (the effective address). It then picks the segment that applies and produces a 20-bit physical address.

Some access types have a fixed segment. An optional override, given as a 2-bit segment code with a valid bit, is honoured for general data operands and for string sources. It is ignored for instruction fetches, stack accesses and string destinations. Each request is marked by an input valid. The result appears one clock later, marked by an output valid.

Top module: `agu_top`

## Requirements
- R1: For a general data access (kind 0), `ea` is the 16-bit wrapped sum of the selected base (`base_sel` 0 none, 1 BX, 2 BP), the selected index (`idx_sel` 0 none, 1 SI, 2 DI) and the displacement.
- R2: `disp_mode` 0 adds no displacement, 1 adds `disp[7:0]` sign-extended to 16 bits, and 2 adds the full `disp[15:0]`.
- R3: `phys` equals (segment value × 16 + `ea`) modulo 2^20.
- R4: An instruction fetch (kind 1) uses segment CS with offset IP, whatever the override inputs are.
- R5: A stack access (kind 2) uses segment SS with offset SP, whatever the override inputs are.
- R6: A general data access defaults to SS when BP is the base and to DS otherwise. When `ovr_valid` is high it uses `ovr_seg` instead.
- R7: A string source (kind 3) uses offset SI and defaults to DS. When `ovr_valid` is high it uses `ovr_seg` instead.
- R8: A string destination (kind 4) uses segment ES with offset DI, and any override is ignored.
- R9: `seg_used` reports the segment that was applied, encoded 0 ES, 1 CS, 2 SS, 3 DS. `ovr_seg` uses the same encoding.
- R10: The outputs are registered with one cycle of latency. `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, `ea`, `seg_used` and `phys` hold their last values.
- R11: During reset and right after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| acc_kind | input | 3 | 0 data, 1 fetch, 2 stack, 3 string source, 4 string destination |
| base_sel | input | 2 | 0 none, 1 BX, 2 BP |
| idx_sel | input | 2 | 0 none, 1 SI, 2 DI |
| disp_mode | input | 2 | 0 none, 1 8-bit sign-extended, 2 16-bit |
| disp | input | 16 | Displacement from the instruction |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| reg_sp | input | 16 | SP value |
| reg_ip | input | 16 | IP value |
| out_valid | output | 1 | Result valid |
| ea | output | 16 | Effective address |
| seg_used | output | 2 | Applied segment code |
| phys | output | 20 | Physical address |

## Verification
The hardest case to reach is an override that is present on an access that refuses it, applied to a segment whose value differs from the default. Only then does a wrong choice show up in `phys` and `seg_used`. The stimulus therefore sweeps every access kind against every override code and against the no-override case, over all base, index and displacement modes. Between steps the register values change, so that each segment register holds a distinct value. A directed step then uses segment value FFFF with a large offset, which forces the 20-bit add to wrap.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int OFS_W  = 16;
    localparam int SEG_SH = 4;
    localparam int PA_W   = OFS_W + SEG_SH;
    localparam int DSP8_W = 8;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    localparam logic [2:0] K_DATA  = 3'd0;
    localparam logic [2:0] K_FETCH = 3'd1;
    localparam logic [2:0] K_STACK = 3'd2;
    localparam logic [2:0] K_SSRC  = 3'd3;
    localparam logic [2:0] K_SDST  = 3'd4;

    localparam logic [1:0] B_BX = 2'd1;
    localparam logic [1:0] B_BP = 2'd2;
    localparam logic [1:0] X_SI = 2'd1;
    localparam logic [1:0] X_DI = 2'd2;
    localparam logic [1:0] D_8  = 2'd1;
    localparam logic [1:0] D_16 = 2'd2;

    typedef struct packed {
        logic             vld;
        logic [OFS_W-1:0] ea;
        seg_e             seg;
        logic [PA_W-1:0]  pa;
    } agu_out_s;
endpackage

// File: rtl/agu_offset.sv
module agu_offset
    import agu_pkg::*;
(
    input  logic [2:0]       kind,
    input  logic [1:0]       base_sel,
    input  logic [1:0]       idx_sel,
    input  logic [1:0]       disp_mode,
    input  logic [OFS_W-1:0] disp,
    input  logic [OFS_W-1:0] bx,
    input  logic [OFS_W-1:0] bp,
    input  logic [OFS_W-1:0] si,
    input  logic [OFS_W-1:0] di,
    input  logic [OFS_W-1:0] sp,
    input  logic [OFS_W-1:0] ip,
    output logic [OFS_W-1:0] ea,
    output logic             bp_based
);
    logic [OFS_W-1:0] base_v, idx_v, disp_v;

    always_comb begin
        case (base_sel)
            B_BX:    base_v = bx;
            B_BP:    base_v = bp;
            default: base_v = '0;
        endcase
        case (idx_sel)
            X_SI:    idx_v = si;
            X_DI:    idx_v = di;
            default: idx_v = '0;
        endcase
        case (disp_mode)
            D_8:     disp_v = {{(OFS_W-DSP8_W){disp[DSP8_W-1]}}, disp[DSP8_W-1:0]};
            D_16:    disp_v = disp;
            default: disp_v = '0;
        endcase
        bp_based = (base_sel == B_BP);
        case (kind)
            K_FETCH: ea = ip;
            K_STACK: ea = sp;
            K_SSRC:  ea = si;
            K_SDST:  ea = di;
            default: ea = base_v + idx_v + disp_v;
        endcase
    end
endmodule

// File: rtl/agu_segsel.sv
module agu_segsel
    import agu_pkg::*;
(
    input  logic [2:0]       kind,
    input  logic             bp_based,
    input  logic             ovr_valid,
    input  logic [1:0]       ovr_seg,
    input  logic [OFS_W-1:0] seg_es,
    input  logic [OFS_W-1:0] seg_cs,
    input  logic [OFS_W-1:0] seg_ss,
    input  logic [OFS_W-1:0] seg_ds,
    output seg_e             sel,
    output logic [OFS_W-1:0] sel_val
);
    logic ovr_ok;

    always_comb begin
        ovr_ok = 1'b0;
        case (kind)
            K_FETCH: sel = SEG_CS;
            K_STACK: sel = SEG_SS;
            K_SDST:  sel = SEG_ES;
            K_SSRC: begin
                sel    = SEG_DS;
                ovr_ok = 1'b1;
            end
            default: begin
                sel    = bp_based ? SEG_SS : SEG_DS;
                ovr_ok = 1'b1;
            end
        endcase
        if (ovr_ok && ovr_valid) sel = seg_e'(ovr_seg);
        case (sel)
            SEG_ES:  sel_val = seg_es;
            SEG_CS:  sel_val = seg_cs;
            SEG_SS:  sel_val = seg_ss;
            default: sel_val = seg_ds;
        endcase
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       acc_kind,
    input  logic [1:0]       base_sel,
    input  logic [1:0]       idx_sel,
    input  logic [1:0]       disp_mode,
    input  logic [OFS_W-1:0] disp,
    input  logic             ovr_valid,
    input  logic [1:0]       ovr_seg,
    input  logic [OFS_W-1:0] seg_es,
    input  logic [OFS_W-1:0] seg_cs,
    input  logic [OFS_W-1:0] seg_ss,
    input  logic [OFS_W-1:0] seg_ds,
    input  logic [OFS_W-1:0] reg_bx,
    input  logic [OFS_W-1:0] reg_bp,
    input  logic [OFS_W-1:0] reg_si,
    input  logic [OFS_W-1:0] reg_di,
    input  logic [OFS_W-1:0] reg_sp,
    input  logic [OFS_W-1:0] reg_ip,
    output logic             out_valid,
    output logic [OFS_W-1:0] ea,
    output logic [1:0]       seg_used,
    output logic [PA_W-1:0]  phys
);
    logic [OFS_W-1:0] ea_c, segv_c;
    logic             bp_c;
    seg_e             seg_c;
    agu_out_s         st_d, st_q;

    agu_offset u_ofs (
        .kind(acc_kind), .base_sel(base_sel), .idx_sel(idx_sel),
        .disp_mode(disp_mode), .disp(disp),
        .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
        .sp(reg_sp), .ip(reg_ip), .ea(ea_c), .bp_based(bp_c)
    );

    agu_segsel u_seg (
        .kind(acc_kind), .bp_based(bp_c), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .sel(seg_c), .sel_val(segv_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ea  = ea_c;
            st_d.seg = seg_c;
            st_d.pa  = {segv_c, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, ea_c};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign ea        = st_q.ea;
    assign seg_used  = st_q.seg;
    assign phys      = st_q.pa;

    AST_FETCH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_kind == K_FETCH) |=> (seg_used == SEG_CS && ea == $past(reg_ip))); // R4
    AST_STACK_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_kind == K_STACK) |=> (seg_used == SEG_SS && ea == $past(reg_sp))); // R5
    AST_DST_ES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_kind == K_SDST) |=> (seg_used == SEG_ES && ea == $past(reg_di))); // R8
    AST_SRC_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_kind == K_SSRC && ovr_valid) |=> (seg_used == $past(ovr_seg))); // R7
    AST_PHYS_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (phys == PA_W'({$past(segv_c), {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, ea}))); // R3
    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid))); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ea) && $stable(phys) && $stable(seg_used))); // R10
endmodule

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  acc_kind = '0;
    logic [1:0]  base_sel = '0, idx_sel = '0, disp_mode = '0, ovr_seg = '0;
    logic        ovr_valid = 1'b0;
    logic [15:0] disp = '0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, reg_sp = '0, reg_ip = '0;
    logic        out_valid;
    logic [15:0] ea;
    logic [1:0]  seg_used;
    logic [19:0] phys;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [15:0] rnd = 16'h1d37;

    always #5 clk = ~clk;

    agu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_kind(acc_kind),
        .base_sel(base_sel), .idx_sel(idx_sel), .disp_mode(disp_mode), .disp(disp),
        .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .reg_sp(reg_sp), .reg_ip(reg_ip),
        .out_valid(out_valid), .ea(ea), .seg_used(seg_used), .phys(phys)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] nxt();
        rnd = rnd * 16'h6255 + 16'h3619;
        return rnd;
    endfunction

    function automatic logic [15:0] exp_ea();
        logic [15:0] s;
        case (acc_kind)
            3'd1: return reg_ip;
            3'd2: return reg_sp;
            3'd3: return reg_si;
            3'd4: return reg_di;
            default: begin
                s = 16'h0;
                if (base_sel == 2'd1) s = s + reg_bx;
                if (base_sel == 2'd2) s = s + reg_bp;
                if (idx_sel == 2'd1) s = s + reg_si;
                if (idx_sel == 2'd2) s = s + reg_di;
                if (disp_mode == 2'd1) s = s + {{8{disp[7]}}, disp[7:0]};
                if (disp_mode == 2'd2) s = s + disp;
                return s;
            end
        endcase
    endfunction

    function automatic logic [1:0] exp_seg();
        case (acc_kind)
            3'd1: return 2'd1;
            3'd2: return 2'd2;
            3'd4: return 2'd0;
            3'd3: return ovr_valid ? ovr_seg : 2'd3;
            default: return ovr_valid ? ovr_seg : ((base_sel == 2'd2) ? 2'd2 : 2'd3);
        endcase
    endfunction

    function automatic logic [19:0] exp_pa(input logic [1:0] s, input logic [15:0] e);
        logic [15:0] v;
        case (s)
            2'd0: v = seg_es;
            2'd1: v = seg_cs;
            2'd2: v = seg_ss;
            default: v = seg_ds;
        endcase
        return 20'(({16'h0, v} * 32'd16 + {16'h0, e}) % 32'h100000);
    endfunction

    function automatic string seg_tag(input logic [2:0] k);
        case (k)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic step_check();
        logic [15:0] e;
        logic [1:0]  s;
        @(negedge clk);
        e = exp_ea();
        s = exp_seg();
        chk("R10 valid", {31'h0, out_valid}, 32'h1);
        chk((acc_kind == 3'd0) ? ((disp_mode == 2'd1) ? "R2 ea" : "R1 ea") : seg_tag(acc_kind),
            {16'h0, ea}, {16'h0, e});
        chk(seg_tag(acc_kind), {30'h0, seg_used}, {30'h0, s});
        chk("R3 phys", {12'h0, phys}, {12'h0, exp_pa(s, e)});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 valid", {31'h0, out_valid}, 32'h0);
        chk("R11 ea", {16'h0, ea}, 32'h0);
        chk("R11 phys", {12'h0, phys}, 32'h0);
        chk("R11 seg", {30'h0, seg_used}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {31'h0, out_valid}, 32'h0);

        for (int k = 0; k < 5; k++)
            for (int b = 0; b < 3; b++)
                for (int x = 0; x < 3; x++)
                    for (int d = 0; d < 3; d++)
                        for (int o = 0; o < 5; o++) begin
                            acc_kind = 3'(k); base_sel = 2'(b); idx_sel = 2'(x);
                            disp_mode = 2'(d);
                            ovr_valid = (o < 4); ovr_seg = 2'(o);
                            disp = nxt();
                            seg_es = nxt(); seg_cs = nxt(); seg_ss = nxt(); seg_ds = nxt();
                            reg_bx = nxt(); reg_bp = nxt(); reg_si = nxt();
                            reg_di = nxt(); reg_sp = nxt(); reg_ip = nxt();
                            in_valid = 1'b1;
                            step_check();
                        end

        // directed: negative 8-bit displacement, wrap of 20-bit add, segment code
        acc_kind = 3'd0; base_sel = 2'd1; idx_sel = 2'd0; disp_mode = 2'd1;
        disp = 16'hAB80; reg_bx = 16'h00A0; ovr_valid = 1'b0;
        seg_ds = 16'hFFFF;
        step_check();
        chk("R2 sign extend", {16'h0, ea}, 32'h0020);
        chk("R3 wrap", {12'h0, phys}, 32'h00010);
        chk("R9 DS code", {30'h0, seg_used}, 32'h3);

        // R10: inputs change with in_valid low, outputs hold
        in_valid = 1'b0; reg_bx = 16'h1234; seg_ds = 16'h0001;
        @(negedge clk);
        chk("R10 valid low", {31'h0, out_valid}, 32'h0);
        chk("R10 ea hold", {16'h0, ea}, 32'h0020);
        chk("R10 phys hold", {12'h0, phys}, 32'h00010);
        chk("R10 seg hold", {30'h0, seg_used}, 32'h3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule